// File: doc/BRIEF.md
# Escalating Watchdog with Keyed Disable

This watchdog watches the expiry pulses of one timer, chosen from a bank of timers by a field in its configuration register. Once started, it groups those pulses into stages of a programmable length. Each completed stage moves it one step up a fixed ladder of actions, and every action on the ladder has its own enable bit. The first step raises a local interrupt, so that software can service the watchdog. Later steps raise a fast interrupt and a remote interrupt, then a debug reset request. The last step raises a power-on reset request, which stays high until the block is reset.

Software services the watchdog by stopping it and then starting it again. Stopping needs a key: software first writes a fixed key value to the key register, and the stop command must be the next register write. Setting the local interrupt enable locks the configuration, and it stays locked until reset. A per-watchdog mask bit in a shared interrupt-enable register gates the local interrupt.

Top module: `wdt_escalator`

## Requirements
- R1: After reset, all five action outputs are low, the watchdog is stopped, and the configuration and interrupt-enable registers read 0.
- R2: While unlocked, a write to the configuration register (offset 0x0) stores bits [16:0] of the write data, and reads return them with bits [31:17] as zero. Field positions: [3:0] timer source, [11:4] stage length, 12 local irq enable, 13 fast irq enable, 14 remote irq enable, 15 debug reset enable, 16 power-on reset enable.
- R3: With a stage length of 1 and every action enabled, the outputs escalate with each counted pulse after start: 1st local irq, 2nd adds fast and remote irq, 3rd adds nothing, 4th adds debug reset, 5th adds power-on reset. Each output changes on the clock edge that samples the pulse.
- R4: Expiry pulses on timers other than the selected source have no effect.
- R5: With a stage length of N, the watchdog advances one stage per N counted pulses. A length of 0 acts as 1.
- R6: Writing bit 1 of the command register (offset 0x8) stops the watchdog, clears its count and drops every output except the power-on reset. This happens only if the previous register write was the key 0x0000C45A to offset 0xC. Any other write in between, including a wrong key, voids the key. A stopped watchdog ignores pulses.
- R7: Writing bit 0 of the command register starts a stopped watchdog with a count of zero. A start while running has no effect. Every command write uses up the key.
- R8: Once bit 12 of the configuration is set, further configuration writes are ignored until reset.
- R9: The local interrupt output is high only when the mask bit at position 16+4*WDT_IDX of the interrupt-enable register (offset 0x4) is set. That register reads back only that bit.
- R10: An action whose enable bit is clear never drives its output, whatever stage is reached.
- R11: Once high, the power-on reset request stays high through stop, start and further pulses, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset, for both write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| tmr_tick | input | NUM_TMR | One-cycle expiry pulses from the timer bank |
| irq_local | output | 1 | Local service interrupt |
| irq_fast | output | 1 | Fast interrupt |
| irq_remote | output | 1 | Remote interrupt |
| rst_debug | output | 1 | Debug reset request |
| rst_por | output | 1 | Power-on reset request (sticky) |

## Verification
Every register write and every counted pulse takes effect on the first rising edge that samples it. So the action outputs and the read data reflect a stimulus one edge later, with no extra pipeline stage. Read data follows reg_addr combinationally. The bench drives stimulus on the falling edge, holds it through exactly one rising edge, and samples on the next falling edge, which is the first point where the new state is visible. The escalation is checked after every single pulse, so that an early or late step in any stage shows up as a mismatch.

// File: rtl/wdt_escalator.sv
module wdt_escalator #(
  parameter int NUM_TMR = 16,
  parameter int WDT_IDX = 0,
  parameter logic [31:0] UNLOCK_KEY = 32'h0000_C45A
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [3:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_TMR-1:0] tmr_tick,
  output logic               irq_local,
  output logic               irq_fast,
  output logic               irq_remote,
  output logic               rst_debug,
  output logic               rst_por
);
  localparam int MASK_BIT = 16 + 4 * WDT_IDX;
  localparam logic [3:0] A_CFG = 4'h0, A_IE = 4'h4, A_CMD = 4'h8, A_KEY = 4'hC;
  localparam logic [2:0] TOP_STAGE = 3'd5;

  logic [16:0] cfg_q;
  logic        ie_q, run_q, unl_q, por_q;
  logic [2:0]  stage_q;
  logic [7:0]  sub_q;

  logic [15:0] tick_pad;
  logic        sel_tick, wr_cmd, do_dis, do_start, count_en, adv;
  logic [7:0]  period;

  assign tick_pad = 16'(tmr_tick);
  assign sel_tick = tick_pad[cfg_q[3:0]];
  assign period   = (cfg_q[11:4] == 8'd0) ? 8'd1 : cfg_q[11:4];
  assign wr_cmd   = reg_we && reg_addr == A_CMD;
  assign do_dis   = wr_cmd && reg_wdata[1] && unl_q;
  assign do_start = wr_cmd && reg_wdata[0] && !run_q && !do_dis;
  assign count_en = run_q && sel_tick && stage_q != TOP_STAGE && !do_dis && !do_start;
  assign adv      = count_en && (sub_q + 8'd1 == period);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      ie_q    <= 1'b0;
      run_q   <= 1'b0;
      unl_q   <= 1'b0;
      por_q   <= 1'b0;
      stage_q <= '0;
      sub_q   <= '0;
    end else begin
      if (reg_we && reg_addr == A_CFG && !cfg_q[12]) cfg_q <= reg_wdata[16:0];
      if (reg_we && reg_addr == A_IE) ie_q <= reg_wdata[MASK_BIT];
      if (reg_we) unl_q <= (reg_addr == A_KEY) && (reg_wdata == UNLOCK_KEY);
      if (do_dis || do_start) begin
        run_q   <= do_start;
        stage_q <= '0;
        sub_q   <= '0;
      end else if (adv) begin
        stage_q <= stage_q + 3'd1;
        sub_q   <= '0;
      end else if (count_en) begin
        sub_q   <= sub_q + 8'd1;
      end
      if (adv && stage_q == TOP_STAGE - 3'd1 && cfg_q[16]) por_q <= 1'b1;
    end
  end

  assign irq_local  = stage_q >= 3'd1 && cfg_q[12] && ie_q;
  assign irq_fast   = stage_q >= 3'd2 && cfg_q[13];
  assign irq_remote = stage_q >= 3'd2 && cfg_q[14];
  assign rst_debug  = stage_q >= 3'd4 && cfg_q[15];
  assign rst_por    = por_q;

  always_comb begin
    case (reg_addr)
      A_CFG:   reg_rdata = {15'd0, cfg_q};
      A_IE:    reg_rdata = 32'(ie_q) << MASK_BIT;
      A_CMD:   reg_rdata = {31'd0, run_q};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdt_escalator_chk.sv
module wdt_escalator_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [3:0]  reg_addr,
  input logic        unl,
  input logic        run,
  input logic [2:0]  stage,
  input logic [16:0] cfg,
  input logic        por
);
  AST_STAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (stage != $past(stage)) |-> (stage == $past(stage) + 3'd1 || stage == 3'd0)); // R3
  AST_STAGE_MAX: assert property (@(posedge clk) disable iff (!rst_n) stage <= 3'd5); // R3
  AST_POR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) por |=> por); // R11
  AST_CFG_LOCK: assert property (@(posedge clk) disable iff (!rst_n) cfg[12] |=> $stable(cfg)); // R8
  AST_STOP_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 4'h8 && !unl && run) |=> run); // R6
  AST_KEY_USED_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 4'h8) |=> !unl); // R7
endmodule

bind wdt_escalator wdt_escalator_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .unl(unl_q), .run(run_q), .stage(stage_q), .cfg(cfg_q), .por(por_q)
);

// File: tb/sim_wdt_escalator.sv
module sim_wdt_escalator;
  localparam int NT = 16;
  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [NT-1:0] tmr_tick = '0;
  logic irq_local, irq_fast, irq_remote, rst_debug, rst_por;
  int n_run = 0, n_fail = 0;
  localparam logic [31:0] KEY = 32'h0000_C45A;
  localparam logic [31:0] ALL = 32'h0001_F000;

  always #2 clk = ~clk;

  wdt_escalator #(.NUM_TMR(NT)) u0 (.*);

  wire [4:0] outs = {rst_por, rst_debug, irq_remote, irq_fast, irq_local};

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; reg_we = 1'b0; tmr_tick = '0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic tick(int i);
    @(negedge clk); tmr_tick[i] = 1'b1;
    @(negedge clk); tmr_tick = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    chk("R1 outputs", 32'(outs), 0);
    rd(4'h0, d); chk("R1 cfg", d, 0);
    rd(4'h4, d); chk("R1 ie", d, 0);
    rd(4'h8, d); chk("R1 stopped", d, 0);
  endtask

  task automatic t_cfg_lock();
    logic [31:0] d;
    do_reset();
    wr(4'h0, 32'hFFFE_0005); rd(4'h0, d); chk("R2 upper bits dropped", d, 32'h5);
    wr(4'h0, 32'h0000_E013); rd(4'h0, d); chk("R2 rewrite", d, 32'hE013);
    wr(4'h0, 32'h0001_F011); rd(4'h0, d); chk("R8 lock write", d, 32'h1F011);
    wr(4'h0, 32'h0); rd(4'h0, d); chk("R8 locked ignores", d, 32'h1F011);
  endtask

  task automatic t_escalate();
    do_reset();
    wr(4'h4, 32'h0001_0000);
    wr(4'h0, ALL | 32'h12);
    wr(4'h8, 32'h1);
    tick(2); chk("R3 pulse1", 32'(outs), 32'h01);
    tick(2); chk("R3 pulse2", 32'(outs), 32'h07);
    tick(2); chk("R3 pulse3", 32'(outs), 32'h07);
    tick(2); chk("R3 pulse4", 32'(outs), 32'h0F);
    tick(2); chk("R3 pulse5", 32'(outs), 32'h1F);
    wr(4'hC, KEY); wr(4'h8, 32'h2);
    chk("R11 por kept after stop", 32'(outs), 32'h10);
    wr(4'h8, 32'h1); tick(2);
    chk("R11 por kept after restart", 32'(outs), 32'h11);
  endtask

  task automatic t_source();
    do_reset();
    wr(4'h4, 32'h0001_0000);
    wr(4'h0, ALL | 32'h12);
    wr(4'h8, 32'h1);
    tick(5); tick(3); tick(0);
    chk("R4 other sources", 32'(outs), 0);
    tick(2); chk("R4 selected source", 32'(outs), 32'h01);
  endtask

  task automatic t_period();
    do_reset();
    wr(4'h4, 32'h0001_0000);
    wr(4'h0, 32'h0000_3030);
    wr(4'h8, 32'h1);
    tick(0); tick(0); chk("R5 before N", 32'(outs), 0);
    tick(0); chk("R5 at N", 32'(outs), 32'h01);
    tick(0); tick(0); chk("R5 mid stage2", 32'(outs), 32'h01);
    tick(0); chk("R5 at 2N", 32'(outs), 32'h03);
  endtask

  task automatic t_key();
    do_reset();
    wr(4'h4, 32'h0001_0000);
    wr(4'h0, ALL | 32'h11);
    wr(4'h8, 32'h1);
    tick(1); chk("R6 stage1", 32'(outs), 32'h01);
    wr(4'h8, 32'h2); chk("R6 stop without key", 32'(outs), 32'h01);
    tick(1); chk("R6 still counting", 32'(outs), 32'h07);
    wr(4'hC, KEY); wr(4'h0, 32'h0); wr(4'h8, 32'h2);
    chk("R6 key voided by other write", 32'(outs), 32'h07);
    wr(4'hC, 32'h0000_C45B); wr(4'h8, 32'h2);
    chk("R6 wrong key", 32'(outs), 32'h07);
    wr(4'h8, 32'h1); chk("R7 start while running", 32'(outs), 32'h07);
    tick(1); chk("R7 count kept", 32'(outs), 32'h07);
    tick(1); chk("R7 count kept to stage4", 32'(outs), 32'h0F);
    wr(4'hC, KEY); wr(4'h8, 32'h2); chk("R6 keyed stop", 32'(outs), 0);
    tick(1); tick(1); chk("R6 stopped ignores pulses", 32'(outs), 0);
    wr(4'h8, 32'h1); tick(1); chk("R7 restart from zero", 32'(outs), 32'h01);
    wr(4'hC, KEY); wr(4'h8, 32'h1); wr(4'h8, 32'h2);
    chk("R7 key used by command", 32'(outs), 32'h01);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    do_reset();
    wr(4'h0, ALL | 32'h11);
    wr(4'h8, 32'h1);
    tick(1); chk("R9 masked", 32'(outs), 0);
    rd(4'h4, d); chk("R9 ie read", d, 0);
    wr(4'h4, 32'hFFFF_FFFF); rd(4'h4, d); chk("R9 ie only own bit", d, 32'h0001_0000);
    chk("R9 unmasked", 32'(outs), 32'h01);
  endtask

  task automatic t_enables();
    do_reset();
    wr(4'h4, 32'h0001_0000);
    wr(4'h0, 32'h0000_1011);
    wr(4'h8, 32'h1);
    for (int k = 0; k < 6; k++) tick(1);
    chk("R10 disabled actions stay low", 32'(outs), 32'h01);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++; n_run++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_cfg_lock();
    t_escalate();
    t_source();
    t_period();
    t_key();
    t_mask();
    t_enables();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule